// File: doc/BRIEF.md
# Carry-Free Signed-Digit Adder/Subtractor

This block adds or subtracts two N-digit signed-digit operands whose digits each take the value -1, 0 or +1. It never ripples a carry. The result is formed in two fixed steps, and both steps have constant depth whatever the value of N.

In the first step, every digit position looks at its own operand pair and at one reference bit taken from the position below. From these it forms a transfer digit and a weight digit. The reference bit is 1 when both lower digits are non-negative. In the second step, every weight digit is added to the transfer digit arriving from the position below. Subtraction uses the same cells: the second operand is negated digit by digit before the reference bit is formed.

The result has N+1 digits and is read as a plain signed-digit vector. An optional output register holds it.

Top module: `msd_addsub`

## Requirements
- R1: Each digit is 2 bits, with digit i at bits [2i+1:2i]. The code 00 is 0, 01 is +1 and 11 is -1. The result never holds the code 10. An input digit coded 10 is read as 0.
- R2: With sub_i=0, the value of sum_o, computed as the sum of digit(i)*2^i over all N+1 digits, equals value(a_i)+value(b_i).
- R3: With sub_i=1, the value of sum_o equals value(a_i)-value(b_i).
- R4: Every step-two sum W(i)+T(i-1) lies in {-1,0,+1}, so the result never needs a second carry.
- R5: Result digit j depends only on input positions j, j-1 and j-2. Changing the inputs at position k leaves every result digit outside k..k+2 unchanged.
- R6: The top result digit is the top transfer digit. Two +1 digits at every position give 18'h15554 for N=8. Two -1 digits at every position give 18'h3FFFC.
- R7: At the lowest position the reference bit is 1 and the incoming transfer is 0. For a=+1, b=0 at position 0 only, in add mode, sum_o is 18'h00007: digit 0 is -1 and digit 1 is +1.
- R8: In add mode the reference bit comes from the raw lower pair. For a=+1 at position 1 and b=+1 at position 0, sum_o is 18'h00013.
- R9: In subtract mode the reference bit comes from a and the negated b. For the R8 operands with sub_i=1, sum_o is 18'h00007.
- R10: With REG_OUT=1, sum_o changes only at a rising edge of clk_i and shows the result of the inputs present before that edge. rst_ni low clears sum_o to all zero digits at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sub_i | input | 1 | 1 selects a-b, 0 selects a+b |
| a_i | input | 2*N | First operand digits |
| b_i | input | 2*N | Second operand digits |
| sum_o | output | 2*(N+1) | Signed-digit result |

## Verification
Random operands with all three digit values are run in both modes and checked by integer value. This separates the add path from the subtract path and catches any broken transfer or weight rule. Fixed patterns with exact expected codes isolate the lowest-position boundary and the top transfer. Pairs of operands chosen so that only the reference bit differs between modes show whether the reference is formed from the raw or the negated subtrahend. Single-position perturbations of a base operand show that the result stays local, which a rippling design would break.

// File: rtl/msd_pkg.sv
package msd_pkg;
  typedef logic [1:0] sd_t;
  localparam sd_t SD_ZERO = 2'b00;
  localparam sd_t SD_POS  = 2'b01;
  localparam sd_t SD_NEG  = 2'b11;

  function automatic logic signed [2:0] sd_val(sd_t d);
    case (d)
      SD_POS:  return 3'sd1;
      SD_NEG:  return -3'sd1;
      default: return 3'sd0;
    endcase
  endfunction

  function automatic sd_t sd_enc(logic signed [2:0] v);
    case (v)
      3'sd1:   return SD_POS;
      -3'sd1:  return SD_NEG;
      default: return SD_ZERO;
    endcase
  endfunction

  // non-negative digit, 10 counts as zero
  function automatic logic sd_is_bin(sd_t d);
    return d != SD_NEG;
  endfunction
endpackage

// File: rtl/msd_operand_neg.sv
module msd_operand_neg
  import msd_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [2*N-1:0] b_i,
  input  logic           neg_i,
  output logic [2*N-1:0] b_o
);
  for (genvar i = 0; i < N; i++) begin : g_dig
    sd_t d;
    assign d = b_i[2*i+:2];
    always_comb begin
      case (d)
        SD_POS:  b_o[2*i+:2] = neg_i ? SD_NEG : SD_POS;
        SD_NEG:  b_o[2*i+:2] = neg_i ? SD_POS : SD_NEG;
        default: b_o[2*i+:2] = SD_ZERO;
      endcase
    end
  end
endmodule

// File: rtl/msd_tw_cell.sv
module msd_tw_cell
  import msd_pkg::*;
(
  input  sd_t  a_i,
  input  sd_t  b_i,
  input  logic g_i,
  output sd_t  t_o,
  output sd_t  w_o
);
  logic signed [2:0] s;
  assign s = sd_val(a_i) + sd_val(b_i);

  always_comb begin
    t_o = SD_ZERO;
    w_o = SD_ZERO;
    case (s)
      3'sd2:  t_o = SD_POS;
      -3'sd2: t_o = SD_NEG;
      3'sd1: begin
        // lower transfer is in {0,+1} when g=1, in {-1,0} when g=0
        t_o = g_i ? SD_POS : SD_ZERO;
        w_o = g_i ? SD_NEG : SD_POS;
      end
      -3'sd1: begin
        t_o = g_i ? SD_ZERO : SD_NEG;
        w_o = g_i ? SD_NEG : SD_POS;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/msd_sum_cell.sv
module msd_sum_cell
  import msd_pkg::*;
(
  input  sd_t w_i,
  input  sd_t t_i,
  output sd_t s_o
);
  logic signed [2:0] v;
  assign v   = sd_val(w_i) + sd_val(t_i);
  assign s_o = sd_enc(v);
endmodule

// File: rtl/msd_addsub.sv
module msd_addsub
  import msd_pkg::*;
#(
  parameter int N       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sub_i,
  input  logic [2*N-1:0]     a_i,
  input  logic [2*N-1:0]     b_i,
  output logic [2*(N+1)-1:0] sum_o
);
  localparam int RW = 2 * (N + 1);

  logic [2*N-1:0] b_eff;
  logic [N:0]     g;
  logic [2*N-1:0] w_vec;
  logic [2*N-1:0] t_vec;
  logic [RW-1:0]  res_c;

  msd_operand_neg #(.N(N)) u_neg (
    .b_i  (b_i),
    .neg_i(sub_i),
    .b_o  (b_eff)
  );

  assign g[0] = 1'b1;

  for (genvar i = 0; i < N; i++) begin : g_pos
    assign g[i+1] = sd_is_bin(a_i[2*i+:2]) & sd_is_bin(b_eff[2*i+:2]);

    msd_tw_cell u_tw (
      .a_i(a_i[2*i+:2]),
      .b_i(b_eff[2*i+:2]),
      .g_i(g[i]),
      .t_o(t_vec[2*i+:2]),
      .w_o(w_vec[2*i+:2])
    );

    if (i == 0) begin : g_lsd
      msd_sum_cell u_sum (
        .w_i(w_vec[1:0]),
        .t_i(SD_ZERO),
        .s_o(res_c[1:0])
      );
    end else begin : g_mid
      msd_sum_cell u_sum (
        .w_i(w_vec[2*i+:2]),
        .t_i(t_vec[2*(i-1)+:2]),
        .s_o(res_c[2*i+:2])
      );
    end
  end

  assign res_c[RW-1-:2] = t_vec[2*N-1-:2];

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sum_o <= '0;
      else         sum_o <= res_c;
    end
  end else begin : g_comb
    assign sum_o = res_c;
  end
endmodule

module msd_addsub_chk
  import msd_pkg::*;
#(
  parameter int N       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               sub_i,
  input logic [2*N-1:0]     a_i,
  input logic [2*N-1:0]     b_i,
  input logic [2*N-1:0]     w_vec,
  input logic [2*N-1:0]     t_vec,
  input logic [2*(N+1)-1:0] res_c,
  input logic [2*(N+1)-1:0] sum_o
);
  localparam int RW = 2 * (N + 1);

  function automatic longint vec_val(logic [RW-1:0] v, int m);
    longint acc = 0;
    for (int i = 0; i < m; i++) acc += longint'(sd_val(v[2*i+:2])) <<< i;
    return acc;
  endfunction

  function automatic logic no_bad(logic [RW-1:0] v);
    for (int i = 0; i < N + 1; i++) if (v[2*i+:2] == 2'b10) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic wt_ok(logic [2*N-1:0] w, logic [2*N-1:0] t);
    int s;
    for (int i = 0; i < N; i++) begin
      s = int'(sd_val(w[2*i+:2])) + ((i == 0) ? 0 : int'(sd_val(t[2*(i-1)+:2])));
      if (s > 1 || s < -1) return 1'b0;
    end
    return 1'b1;
  endfunction

  longint av, bv;
  logic signed [2:0] top_s, low_s;
  assign av    = vec_val({2'b00, a_i}, N);
  assign bv    = vec_val({2'b00, b_i}, N);
  assign top_s = sd_val(a_i[2*N-1-:2]) + (sub_i ? -sd_val(b_i[2*N-1-:2]) : sd_val(b_i[2*N-1-:2]));
  assign low_s = sd_val(a_i[1:0]) + sd_val(b_i[1:0]);

  a_r1_no_bad_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_bad(res_c) && no_bad(sum_o));

  a_r2_add_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sub_i |-> vec_val(res_c, N + 1) == av + bv);

  a_r3_sub_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_i |-> vec_val(res_c, N + 1) == av - bv);

  a_r4_wt_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wt_ok(w_vec, t_vec));

  a_r6_top_pos: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (top_s == 3'sd2) |-> res_c[RW-1-:2] == SD_POS);

  a_r6_top_neg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (top_s == -3'sd2) |-> res_c[RW-1-:2] == SD_NEG);

  a_r7_lsd_parity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_c[1:0] != SD_ZERO) == low_s[0]);

  if (REG_OUT) begin : g_reg_chk
    a_r10_reg_stage: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> sum_o == $past(res_c));
  end
endmodule

bind msd_addsub msd_addsub_chk #(.N(N), .REG_OUT(REG_OUT)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .sub_i (sub_i),
  .a_i   (a_i),
  .b_i   (b_i),
  .w_vec (w_vec),
  .t_vec (t_vec),
  .res_c (res_c),
  .sum_o (sum_o)
);

// File: tb/msd_addsub_tb.sv
module msd_addsub_tb;
  localparam int N  = 8;
  localparam int RW = 2 * (N + 1);

  typedef struct {
    int             kind;   // 0 value, 1 exact code, 2 value + locality
    string          req;
    longint         exp_val;
    logic [RW-1:0]  exp_code;
    logic [RW-1:0]  keep;
  } item_t;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b1;
  logic          sub_i = 1'b0;
  logic [2*N-1:0] a_i = '0;
  logic [2*N-1:0] b_i = '0;
  logic [RW-1:0]  sum_o;

  int n_checks = 0;
  int n_err    = 0;
  item_t q[$];
  logic [RW-1:0] prev_res = '0;

  always #5 clk_i = ~clk_i;

  msd_addsub #(.N(N), .REG_OUT(1'b1)) u_dut (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sub_i (sub_i),
    .a_i   (a_i),
    .b_i   (b_i),
    .sum_o (sum_o)
  );

  function automatic longint dval(logic [1:0] d);
    return (d == 2'b01) ? 1 : (d == 2'b11) ? -1 : 0;
  endfunction

  function automatic longint vval(logic [RW-1:0] v, int m);
    longint acc = 0;
    for (int i = 0; i < m; i++) acc += dval(v[2*i+:2]) <<< i;
    return acc;
  endfunction

  function automatic logic codes_ok(logic [RW-1:0] v);
    for (int i = 0; i < N + 1; i++) if (v[2*i+:2] == 2'b10) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [2*N-1:0] rnd_op();
    logic [2*N-1:0] r;
    for (int i = 0; i < N; i++) begin
      case ($urandom_range(0, 2))
        0:       r[2*i+:2] = 2'b00;
        1:       r[2*i+:2] = 2'b01;
        default: r[2*i+:2] = 2'b11;
      endcase
    end
    return r;
  endfunction

  task automatic check(logic ok, string req, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(logic s, logic [2*N-1:0] a, logic [2*N-1:0] b,
                       int kind, string req, logic [RW-1:0] code, logic [RW-1:0] keep);
    item_t it;
    @(negedge clk_i);
    sub_i = s; a_i = a; b_i = b;
    it.kind     = kind;
    it.req      = req;
    it.exp_val  = s ? vval({2'b00, a}, N) - vval({2'b00, b}, N)
                    : vval({2'b00, a}, N) + vval({2'b00, b}, N);
    it.exp_code = code;
    it.keep     = keep;
    q.push_back(it);
  endtask

  // scoreboard monitor
  initial begin
    item_t it;
    forever begin
      @(posedge clk_i);
      #2;
      if (q.size() > 0) begin
        it = q.pop_front();
        if (it.kind == 1) begin
          check(sum_o == it.exp_code, it.req, longint'(sum_o), longint'(it.exp_code));
        end else begin
          check(vval(sum_o, N + 1) == it.exp_val, it.req, vval(sum_o, N + 1), it.exp_val);
          check(codes_ok(sum_o), "R1 R4 digit range", longint'(sum_o), 0);
          if (it.kind == 2)
            check((sum_o & it.keep) == (prev_res & it.keep), it.req,
                  longint'(sum_o & it.keep), longint'(prev_res & it.keep));
        end
        prev_res = sum_o;
      end
    end
  end

  initial begin
    #(200000 * 10);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    logic [2*N-1:0] a, b;
    logic [RW-1:0] keep;
    int k;
    #1 rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    #2 check(sum_o == '0, "R10 reset clears", longint'(sum_o), 0);
    @(negedge clk_i) rst_ni = 1'b1;

    drive(1'b0, 16'h0001, 16'h0000, 1, "R7 lowest position", 18'h00007, '0);
    drive(1'b0, 16'h0004, 16'h0001, 1, "R8 add reference", 18'h00013, '0);
    drive(1'b1, 16'h0004, 16'h0001, 1, "R9 sub reference", 18'h00007, '0);
    drive(1'b0, 16'h5555, 16'h5555, 1, "R6 top transfer +1", 18'h15554, '0);
    drive(1'b0, 16'hFFFF, 16'hFFFF, 1, "R6 top transfer -1", 18'h3FFFC, '0);
    drive(1'b0, 16'h0002, 16'h0000, 1, "R1 input code 10 as zero", 18'h00000, '0);
    drive(1'b1, 16'h5555, 16'h5555, 0, "R3 a-a", '0, '0);

    for (int n = 0; n < 200; n++) drive(1'b0, rnd_op(), rnd_op(), 0, "R2 random add", '0, '0);
    for (int n = 0; n < 200; n++) drive(1'b1, rnd_op(), rnd_op(), 0, "R3 random sub", '0, '0);

    for (int n = 0; n < 40; n++) begin
      a = rnd_op();
      b = rnd_op();
      drive(n[0], a, b, 0, "R5 base", '0, '0);
      k = $urandom_range(0, N - 1);
      keep = '0;
      for (int j = 0; j < N + 1; j++) if (j < k || j > k + 2) keep[2*j+:2] = 2'b11;
      a[2*k+:2] = (a[2*k+:2] == 2'b01) ? 2'b11 : 2'b01;
      drive(n[0], a, b, 2, "R5 locality", '0, keep);
    end

    wait (q.size() == 0);
    @(posedge clk_i);
    #2 prev_res = sum_o;
    @(negedge clk_i);
    sub_i = 1'b0; a_i = 16'h5555; b_i = 16'h5555;
    #1 check(sum_o == prev_res, "R10 holds until edge", longint'(sum_o), longint'(prev_res));
    @(posedge clk_i);
    #2 check(sum_o == 18'h15554, "R10 updates at edge", longint'(sum_o), 18'h15554);
    @(negedge clk_i) rst_ni = 1'b0;
    #1 check(sum_o == '0, "R10 async reset", longint'(sum_o), 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule